// File: doc/BRIEF.md
# I2C address-match and direction status

This block keeps two status flags for an I2C bus interface. The first flag says that the first byte after a start condition carried this node's 7-bit address. The second flag says whether the node is in the transmit state or the receive state. The flags follow separate set and clear rules for the master role and the slave role. A role input picks which set of rules applies.

Start and stop detection, the SCL edge strobes, the bit counter and the sampled SDA value all arrive as single-cycle synchronous inputs in the system clock domain. Start/stop generation, clock stretching and the shift register are outside the block and reach it only as strobes. From the direction flag the block derives the SDA output enable. In the receive state SDA is released to high impedance. In the transmit state SDA is driven once the ninth clock of the first byte has fallen.

Top module: `i2c_role_status`

## Requirements
- R1: Bits are counted 1 to 9 within a byte, MSB first. Bits 1 to 7 of the first byte after a start form the address, and bit 8 is the direction bit. On the rising SCL strobe with count 8 of that byte, `addr_match` goes to 1 in the following cycle if the address equals `local_addr`. Later bytes never change the address comparison.
- R2: `addr_match` goes to 0 in the cycle after any of these events: start detection, stop detection, an `exit_pulse`, or `if_en` falling. It is also 0 during reset. A clear wins over a set in the same cycle.
- R3: With `role_master`=1, `xmit_dir` goes to 1 in the cycle after `mst_start_gen`. On the count-8 rising strobe of the first byte, a direction bit of 0 makes it 1 and a direction bit of 1 makes it 0.
- R4: With `role_master`=0, the count-8 rising strobe of the first byte sets `xmit_dir` to the direction bit. Start detection clears `xmit_dir`.
- R5: In both roles, `xmit_dir` goes to 0 in the cycle after any of these events: stop detection, `exit_pulse`, `if_en` falling, `wait_cancel`, or a 0-to-1 change of `arb_lost`.
- R6: `xmit_dir` is held at 0 whenever `role_master`, `ext_code` and the next `addr_match` are all 0. This means an unaddressed slave never enters the transmit state unless `ext_code` is 1.
- R7: `sda_oe` is 1 only when `xmit_dir` is 1 and the falling SCL strobe with count 9 of the first byte has occurred since the last start.
- R8: A `wait_cancel` while `xmit_dir`=1 drops both `xmit_dir` and `sda_oe` to 0 in the next cycle. `addr_match` keeps its value.
- R9: While `if_en` is 0, no event sets either flag, and both flags read 0.
- R10: Data bytes after the first byte leave `addr_match`, `xmit_dir` and `sda_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Interface enable |
| role_master | input | 1 | 1 selects the master rules, 0 selects the slave rules |
| ext_code | input | 1 | Extension code received (external flag) |
| local_addr | input | ADDR_W | Local slave address |
| start_det | input | 1 | Start condition detected (pulse) |
| stop_det | input | 1 | Stop condition detected (pulse) |
| mst_start_gen | input | 1 | Master generated a start (pulse) |
| exit_pulse | input | 1 | Leave the current communication (pulse) |
| wait_cancel | input | 1 | Wait released (pulse) |
| arb_lost | input | 1 | Arbitration lost (level) |
| scl_rise | input | 1 | SCL rising edge strobe |
| scl_fall | input | 1 | SCL falling edge strobe |
| bit_cnt | input | CNT_W | Bit index 1 to 9, valid with the SCL strobes |
| sda_bit | input | 1 | SDA value sampled with `scl_rise` |
| addr_match | output | 1 | Address matched |
| xmit_dir | output | 1 | 1 = transmit state, 0 = receive state |
| sda_oe | output | 1 | SDA output enable |

## Verification
The bench uses the default parameters: a 7-bit address and a 4-bit bit counter. With these values every first-byte position from 1 to 9 appears, including the count-8 direction sample and the count-9 falling edge that arms the output. A behavioural model built from integers is compared against the outputs on every cycle. It covers both roles, matching and non-matching addresses, repeated starts, data bytes after the first byte, and each clear source, including an `arb_lost` rise and `if_en` dropping while a transfer is active.

// File: rtl/i2c_rs_pkg.sv
`timescale 1ns/1ps
package i2c_rs_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef struct packed {
        logic coi;    // address matched
        logic trc;    // transmit state
        logic en_q;   // last enable, for edge detect
        logic arb_q;  // last arbitration-lost, for edge detect
    } flag_st_t;

endpackage

// File: rtl/i2c_rs_frame.sv
`timescale 1ns/1ps
module i2c_rs_frame #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              exit_pulse,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              sda_bit,
    output logic              addr_stb,
    output logic [ADDR_W-1:0] addr_val,
    output logic              dir_bit,
    output logic              ninth_fall,
    output logic              armed
);
    localparam int DIR_IDX = ADDR_W + 1;
    localparam int ACK_IDX = ADDR_W + 2;

    typedef struct packed {
        logic              in_first;
        logic              armed;
        logic [ADDR_W-1:0] sh;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic      kill;

    assign addr_stb   = st_q.in_first && scl_rise && (bit_cnt == CNT_W'(DIR_IDX));
    assign ninth_fall = st_q.in_first && scl_fall && (bit_cnt == CNT_W'(ACK_IDX));
    assign addr_val   = st_q.sh;
    assign dir_bit    = sda_bit;
    assign armed      = st_q.armed;
    assign kill       = !if_en || exit_pulse || stop_det;

    always_comb begin
        st_d = st_q;
        if (st_q.in_first && scl_rise && (bit_cnt <= CNT_W'(ADDR_W))) begin
            st_d.sh = {st_q.sh[ADDR_W-2:0], sda_bit};
        end
        if (ninth_fall) begin
            st_d.in_first = 1'b0;
            st_d.armed    = 1'b1;
        end
        if (start_det) begin
            st_d.in_first = 1'b1;
            st_d.armed    = 1'b0;
            st_d.sh       = '0;
        end
        if (kill) begin
            st_d.in_first = 1'b0;
            st_d.armed    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ARM_AFTER_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(ninth_fall)); // R7

endmodule

// File: rtl/i2c_rs_flags.sv
`timescale 1ns/1ps
module i2c_rs_flags
    import i2c_rs_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              role_master,
    input  logic              ext_code,
    input  logic              exit_pulse,
    input  logic              wait_cancel,
    input  logic              arb_lost,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              mst_start_gen,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              dir_bit,
    input  logic [ADDR_W-1:0] local_addr,
    output logic              coi,
    output logic              trc
);
    flag_st_t st_d, st_q;
    logic     en_fall, arb_rise, is_master, trc_clr;

    assign is_master = (role_e'(role_master) == ROLE_MASTER);
    assign en_fall   = st_q.en_q && !if_en;
    assign arb_rise  = arb_lost && !st_q.arb_q;
    assign trc_clr   = stop_det || exit_pulse || en_fall || wait_cancel || arb_rise || !if_en;

    always_comb begin
        st_d       = st_q;
        st_d.en_q  = if_en;
        st_d.arb_q = arb_lost;

        // address match
        if (if_en && addr_stb && (addr_val == local_addr)) begin
            st_d.coi = 1'b1;
        end
        if (start_det || stop_det || exit_pulse || en_fall || !if_en) begin
            st_d.coi = 1'b0;
        end

        // direction
        if (if_en) begin
            if (is_master) begin
                if (mst_start_gen) st_d.trc = 1'b1;
                if (addr_stb)      st_d.trc = !dir_bit;
            end else begin
                if (addr_stb)      st_d.trc = dir_bit;
                if (start_det)     st_d.trc = 1'b0;
            end
        end
        if (trc_clr) begin
            st_d.trc = 1'b0;
        end
        if (!is_master && !ext_code && !st_d.coi) begin
            st_d.trc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coi = st_q.coi;
    assign trc = st_q.trc;

    AST_MATCH_ONLY_AT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coi) |-> $past(addr_stb)); // R1
    AST_STOP_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !coi); // R2
    AST_ARB_CLEARS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |=> !trc); // R5
    AST_WAIT_CLEARS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cancel |=> !trc); // R8
    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> (!coi && !trc)); // R9

endmodule

// File: rtl/i2c_role_status.sv
`timescale 1ns/1ps
module i2c_role_status #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              role_master,
    input  logic              ext_code,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              mst_start_gen,
    input  logic              exit_pulse,
    input  logic              wait_cancel,
    input  logic              arb_lost,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              sda_bit,
    output logic              addr_match,
    output logic              xmit_dir,
    output logic              sda_oe
);
    logic              addr_stb, dir_bit, ninth_fall, armed;
    logic [ADDR_W-1:0] addr_val;

    i2c_rs_frame #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_en      (if_en),
        .exit_pulse (exit_pulse),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bit_cnt    (bit_cnt),
        .sda_bit    (sda_bit),
        .addr_stb   (addr_stb),
        .addr_val   (addr_val),
        .dir_bit    (dir_bit),
        .ninth_fall (ninth_fall),
        .armed      (armed)
    );

    i2c_rs_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .if_en         (if_en),
        .role_master   (role_master),
        .ext_code      (ext_code),
        .exit_pulse    (exit_pulse),
        .wait_cancel   (wait_cancel),
        .arb_lost      (arb_lost),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .mst_start_gen (mst_start_gen),
        .addr_stb      (addr_stb),
        .addr_val      (addr_val),
        .dir_bit       (dir_bit),
        .local_addr    (local_addr),
        .coi           (addr_match),
        .trc           (xmit_dir)
    );

    assign sda_oe = xmit_dir && armed;

    AST_OE_RECEIVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!xmit_dir) |-> !sda_oe); // R7

endmodule

// File: tb/i2c_role_status_bench.sv
`timescale 1ns/1ps
module i2c_role_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       if_en = 1'b0, role_master = 1'b0, ext_code = 1'b0;
    logic [6:0] local_addr = 7'h2A;
    logic       start_det = 1'b0, stop_det = 1'b0, mst_start_gen = 1'b0;
    logic       exit_pulse = 1'b0, wait_cancel = 1'b0, arb_lost = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_bit = 1'b0;
    logic [3:0] bit_cnt = 4'd0;
    logic       addr_match, xmit_dir, sda_oe;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_first, m_armed, m_sh, m_coi, m_trc, m_en, m_arb;

    always #10 clk = ~clk;

    i2c_role_status u_i2c_role_status (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .role_master(role_master),
        .ext_code(ext_code), .local_addr(local_addr), .start_det(start_det),
        .stop_det(stop_det), .mst_start_gen(mst_start_gen), .exit_pulse(exit_pulse),
        .wait_cancel(wait_cancel), .arb_lost(arb_lost), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bit_cnt(bit_cnt), .sda_bit(sda_bit),
        .addr_match(addr_match), .xmit_dir(xmit_dir), .sda_oe(sda_oe)
    );

    always @(posedge clk) begin
        int stb, nf, enf, arr, n_coi, n_trc, n_first, n_armed, n_sh;
        if (!rst_n) begin
            m_first = 0; m_armed = 0; m_sh = 0; m_coi = 0; m_trc = 0; m_en = 0; m_arb = 0;
        end else begin
            stb = (m_first != 0 && scl_rise && bit_cnt == 8) ? 1 : 0;
            nf  = (m_first != 0 && scl_fall && bit_cnt == 9) ? 1 : 0;
            enf = (m_en != 0 && !if_en) ? 1 : 0;
            arr = (arb_lost && m_arb == 0) ? 1 : 0;
            n_coi = m_coi;
            if (if_en && stb != 0 && m_sh == int'(local_addr)) n_coi = 1;
            if (start_det || stop_det || exit_pulse || enf != 0 || !if_en) n_coi = 0;
            n_trc = m_trc;
            if (if_en) begin
                if (role_master) begin
                    if (mst_start_gen) n_trc = 1;
                    if (stb != 0) n_trc = sda_bit ? 0 : 1;
                end else begin
                    if (stb != 0) n_trc = sda_bit ? 1 : 0;
                    if (start_det) n_trc = 0;
                end
            end
            if (stop_det || exit_pulse || enf != 0 || wait_cancel || arr != 0 || !if_en) n_trc = 0;
            if (!role_master && !ext_code && n_coi == 0) n_trc = 0;
            n_first = m_first; n_armed = m_armed; n_sh = m_sh;
            if (m_first != 0 && scl_rise && bit_cnt <= 7) n_sh = ((m_sh * 2) + int'(sda_bit)) % 128;
            if (nf != 0) begin n_first = 0; n_armed = 1; end
            if (start_det) begin n_first = 1; n_armed = 0; n_sh = 0; end
            if (!if_en || exit_pulse || stop_det) begin n_first = 0; n_armed = 0; end
            m_coi = n_coi; m_trc = n_trc; m_first = n_first; m_armed = n_armed; m_sh = n_sh;
            m_en = int'(if_en); m_arb = int'(arb_lost);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(addr_match) != m_coi || int'(xmit_dir) != m_trc ||
                int'(sda_oe) != ((m_trc != 0 && m_armed != 0) ? 1 : 0)) begin
                errors++;
                $display("FAIL R1 R3 R4 model compare t=%0t act=%b%b%b exp=%0d%0d%0d",
                         $time, addr_match, xmit_dir, sda_oe, m_coi, m_trc,
                         (m_trc != 0 && m_armed != 0) ? 1 : 0);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int idx);
        sda_bit = b; bit_cnt = 4'(idx); scl_rise = 1'b1;
        @(negedge clk);
        scl_rise = 1'b0; scl_fall = 1'b1;
        @(negedge clk);
        scl_fall = 1'b0;
    endtask

    task automatic send_first8(input logic [7:0] v);
        for (int i = 1; i <= 8; i++) send_bit(v[8-i], i);
    endtask

    task automatic send_byte(input logic [7:0] v);
        send_first8(v);
        send_bit(1'b0, 9);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        chk("R2 reset addr_match", addr_match, 1'b0);
        chk("R2 reset xmit_dir", xmit_dir, 1'b0);
        rst_n = 1'b1; if_en = 1'b1;
        @(negedge clk);

        // slave, matching read
        pulse(start_det);
        send_first8({7'h2A, 1'b1});
        chk("R1 match set", addr_match, 1'b1);
        chk("R4 slave dir one", xmit_dir, 1'b1);
        chk("R7 oe before ninth fall", sda_oe, 1'b0);
        send_bit(1'b0, 9);
        chk("R7 oe after ninth fall", sda_oe, 1'b1);
        send_byte(8'h01);
        chk("R10 data byte match", addr_match, 1'b1);
        chk("R10 data byte dir", xmit_dir, 1'b1);
        pulse(wait_cancel);
        chk("R8 wait clears dir", xmit_dir, 1'b0);
        chk("R8 wait clears oe", sda_oe, 1'b0);
        chk("R8 wait keeps match", addr_match, 1'b1);
        pulse(stop_det);
        chk("R2 stop clears match", addr_match, 1'b0);

        // slave, mismatch with direction 1
        pulse(start_det);
        send_byte({7'h15, 1'b1});
        chk("R1 mismatch", addr_match, 1'b0);
        chk("R6 unaddressed slave receive", xmit_dir, 1'b0);

        // slave, matching write then repeated start
        pulse(start_det);
        send_byte({7'h2A, 1'b0});
        chk("R1 match write", addr_match, 1'b1);
        chk("R4 slave dir zero", xmit_dir, 1'b0);
        pulse(start_det);
        chk("R2 start clears match", addr_match, 1'b0);

        // slave read then start clears direction
        send_byte({7'h2A, 1'b1});
        chk("R4 read after restart", xmit_dir, 1'b1);
        pulse(start_det);
        chk("R4 start clears dir", xmit_dir, 1'b0);

        // extension code keeps an unaddressed transmit
        ext_code = 1'b1;
        send_byte({7'h11, 1'b1});
        chk("R6 extension keeps dir", xmit_dir, 1'b1);
        pulse(exit_pulse);
        chk("R5 exit clears dir", xmit_dir, 1'b0);
        ext_code = 1'b0;

        // exit clears a match
        pulse(start_det);
        send_byte({7'h2A, 1'b0});
        pulse(exit_pulse);
        chk("R2 exit clears match", addr_match, 1'b0);

        // master role
        role_master = 1'b1;
        pulse(mst_start_gen);
        chk("R3 start gen sets dir", xmit_dir, 1'b1);
        pulse(start_det);
        send_byte({7'h10, 1'b0});
        chk("R3 master write keeps dir", xmit_dir, 1'b1);
        arb_lost = 1'b1;
        @(negedge clk);
        chk("R5 arb rise clears dir", xmit_dir, 1'b0);
        arb_lost = 1'b0;
        pulse(stop_det);
        pulse(mst_start_gen);
        pulse(start_det);
        send_byte({7'h10, 1'b1});
        chk("R3 master read clears dir", xmit_dir, 1'b0);
        pulse(stop_det);

        // enable falls while active
        pulse(mst_start_gen);
        pulse(start_det);
        send_first8({7'h2A, 1'b0});
        chk("R1 master own address", addr_match, 1'b1);
        if_en = 1'b0;
        @(negedge clk);
        chk("R5 enable fall clears dir", xmit_dir, 1'b0);
        chk("R2 enable fall clears match", addr_match, 1'b0);

        // disabled: nothing sets
        pulse(mst_start_gen);
        pulse(start_det);
        send_byte({7'h2A, 1'b0});
        chk("R9 disabled match", addr_match, 1'b0);
        chk("R9 disabled dir", xmit_dir, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule